// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for every beat of a short wrapping burst. A start address is captured on a load cycle. On each advance cycle after that, the block steps a small beat counter and presents the next address of the burst. The upper address bits come from the captured start address and do not change. The low bits walk through an aligned block of 2^CNT_W words. With the default CNT_W of 2, that block is four words.

Two visiting orders are available. In the linear order, the beat count is added to the start offset and the sum wraps within the block. In the interleaved order, the start offset is XORed with the beat count. The order input is captured together with the start address. A whole burst therefore follows one order, even if the input moves while the burst runs.

An active-low clock enable freezes all state and ignores every other synchronous input. The address output is registered and shows the new beat on the edge after the command.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after it rises until the first enabled command, addr_o is zero.
- R2: With clk_en_n low and advance low at a rising edge, addr_o equals ext_addr after that edge. The beat count restarts at 0.
- R3: With clk_en_n low and advance high at a rising edge, the beat count k increases by one modulo 2^CNT_W. After the edge, addr_o shows the address for the new k.
- R4: In linear order (interleave captured as 0), the low CNT_W bits of addr_o are (start offset + k) mod 2^CNT_W.
- R5: In interleaved order (interleave captured as 1), the low CNT_W bits of addr_o are start offset XOR k.
- R6: The order is taken from the interleave input only on a load cycle. A change of interleave during advance cycles has no effect on the sequence.
- R7: The bits of addr_o above the low CNT_W bits equal those of the loaded address for every beat of the burst.
- R8: With clk_en_n high, addr_o and the beat count keep their values, whatever advance, ext_addr and interleave do.
- R9: Advances past the last beat keep wrapping. Beat 2^CNT_W shows the same address as beat 0, and the sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| advance | input | 1 | 1 steps the burst, 0 loads ext_addr |
| ext_addr | input | ADDR_W | Start address captured on a load |
| interleave | input | 1 | Burst order captured on a load: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the block with ADDR_W = 8 and CNT_W = 2. With these values, every start offset in both orders can be swept over more than one full wrap of the four-beat block. Several upper-bit patterns are used across those sweeps. Expected addresses come from the sum and XOR formulas in the bench. Directed sequences also cover a held clock enable that carries a conflicting load, and an order input that toggles in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_offset_calc.sv
module burst_offset_calc
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_off,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] offs
);

    logic [CNT_W-1:0] lin_offs;
    logic [CNT_W-1:0] ilv_offs;

    // Linear: add and let the carry fall off the top (wrap in block).
    assign lin_offs = start_off + beat;

    // Interleaved: per-bit XOR, one gate per bit.
    genvar gi;
    generate
        for (gi = 0; gi < CNT_W; gi++) begin : g_ilv
            assign ilv_offs[gi] = start_off[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        offs = (order == ORDER_INTERLEAVE) ? ilv_offs : lin_offs;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] beat_q,
    output logic [CNT_W-1:0] beat_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] beat;
    } ctr_s;

    ctr_s st_d, st_q;

    assign beat_nxt = CNT_W'(st_q.beat + 1'b1);

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (clear)     st_d.beat = '0;
            else if (step) st_d.beat = beat_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_q = st_q.beat;

    assert_step_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && step) |=> (beat_q == CNT_W'($past(beat_q) + 1'b1)));

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clear) |=> (beat_q == '0));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              interleave,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        burst_order_e      order;
        logic [ADDR_W-1:0] addr;
    } gen_s;

    gen_s st_d, st_q;

    logic             en;
    logic             do_load;
    logic             do_step;
    logic [CNT_W-1:0] beat_q;
    logic [CNT_W-1:0] beat_nxt;
    logic [CNT_W-1:0] offs_nxt;

    assign en      = !clk_en_n;
    assign do_load = en && !advance;
    assign do_step = en && advance;

    burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .clear    (!advance),
        .step     (advance),
        .beat_q   (beat_q),
        .beat_nxt (beat_nxt)
    );

    burst_offset_calc #(.CNT_W(CNT_W)) u_offs (
        .start_off (st_q.base[CNT_W-1:0]),
        .beat      (beat_nxt),
        .order     (st_q.order),
        .offs      (offs_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (do_load) begin
            st_d.base  = ext_addr;
            st_d.order = burst_order_e'(interleave);
            st_d.addr  = ext_addr;
        end else if (do_step) begin
            st_d.addr  = {st_q.base[ADDR_W-1:CNT_W], offs_nxt};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{base: '0, order: ORDER_LINEAR, addr: '0};
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 || !rst_n));

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (addr_o == $past(ext_addr)));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && st_q.order == ORDER_LINEAR) |=>
        (CNT_W'(addr_o[CNT_W-1:0] - st_q.base[CNT_W-1:0]) == beat_q));

    assert_interleave_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_step && st_q.order == ORDER_INTERLEAVE) |=>
        ((addr_o[CNT_W-1:0] ^ st_q.base[CNT_W-1:0]) == beat_q));

    assert_order_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> $stable(st_q.order));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> (addr_o[ADDR_W-1:CNT_W] == $past(st_q.base[ADDR_W-1:CNT_W])));

    assert_hold_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(addr_o) && $stable(beat_q)));

    initial begin
        assert_width_ok: assert (UP_W >= 1);
    end

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;

    localparam int AW = 8;
    localparam int CW = 2;
    localparam int NB = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b1;
    logic          advance = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          interleave = 1'b0;
    logic [AW-1:0] addr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
        .ext_addr(ext_addr), .interleave(interleave), .addr_o(addr_o)
    );

    function automatic logic [AW-1:0] model(input logic [AW-1:0] start, input int k,
                                            input logic ilv);
        logic [CW-1:0] s;
        logic [CW-1:0] kk;
        logic [CW-1:0] lo;
        s  = start[CW-1:0];
        kk = CW'(k % NB);
        lo = ilv ? (s ^ kk) : CW'((int'(s) + k) % NB);
        return {start[AW-1:CW], lo};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    task automatic cyc(input logic en_n, input logic adv, input logic [AW-1:0] a,
                       input logic m);
        clk_en_n = en_n; advance = adv; ext_addr = a; interleave = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] st;
        @(negedge clk);
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 8'hFF, 1'b1); // advance with nothing loaded: base zero, linear
        check("R1", 8'h01);
        cyc(1'b0, 1'b0, 8'h00, 1'b0);

        // R4 R5 R7 R9: exhaustive start offsets, both orders, past one wrap
        for (int m = 0; m < 2; m++) begin
            for (int up = 0; up < 4; up++) begin
                for (int s = 0; s < NB; s++) begin
                    st = {6'(up * 21 + 3), 2'(s)};
                    cyc(1'b0, 1'b0, st, 1'(m));
                    check("R2", st);
                    for (int k = 1; k <= 2 * NB + 1; k++) begin
                        cyc(1'b0, 1'b1, 8'h00, 1'(m));
                        if (k >= NB) check("R9", model(st, k, 1'(m)));
                        else if (m == 1) check("R5", model(st, k, 1'b1));
                        else check("R4", model(st, k, 1'b0));
                        if (addr_o[AW-1:CW] != st[AW-1:CW]) begin
                            n_chk++; n_fail++;
                            $display("FAIL R7: upper=%h expected=%h",
                                     addr_o[AW-1:CW], st[AW-1:CW]);
                        end else n_chk++;
                    end
                end
            end
        end

        // R6: order toggles during advance, no effect
        st = 8'hA6;
        cyc(1'b0, 1'b0, st, 1'b1);
        for (int k = 1; k <= NB; k++) begin
            cyc(1'b0, 1'b1, 8'h00, 1'(k & 1) ^ 1'b1);
            check("R6", model(st, k, 1'b1));
        end
        st = 8'h5B;
        cyc(1'b0, 1'b0, st, 1'b0);
        for (int k = 1; k <= NB; k++) begin
            cyc(1'b0, 1'b1, 8'h00, 1'b1);
            check("R6", model(st, k, 1'b0));
        end

        // R8: hold ignores load, advance and order
        st = 8'h3D;
        cyc(1'b0, 1'b0, st, 1'b1);
        cyc(1'b0, 1'b1, 8'h00, 1'b1);
        check("R3", model(st, 1, 1'b1));
        cyc(1'b1, 1'b0, 8'hC4, 1'b0);
        check("R8", model(st, 1, 1'b1));
        cyc(1'b1, 1'b1, 8'h11, 1'b0);
        check("R8", model(st, 1, 1'b1));
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        check("R8", model(st, 2, 1'b1));

        // R2: reload mid-burst restarts beat count
        st = 8'h72;
        cyc(1'b0, 1'b0, st, 1'b0);
        check("R2", st);
        cyc(1'b0, 1'b1, 8'h00, 1'b0);
        check("R3", model(st, 1, 1'b0));

        // R1: reset mid-burst clears output
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 8'h00, 1'b0);
        check("R1", '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule